// File: doc/BRIEF.md
# Segmented Operand Chain Register File

This block is a register file cut into a linear chain of bank segments. Each segment owns a contiguous slice of the architectural registers. Two operand tokens enter at the decode end of the chain and move one segment per cycle toward the ALU end. A token carries a valid bit, a flag that says whether its payload is still a register number or already a data value, the register number it came from, and a data field. An immediate enters already marked as a value. A register operand enters marked as a number. A segment that does not own the number lets the token through unchanged. The owning segment reads its bank, stores the contents into the token and marks it resolved.

Writebacks enter at the ALU end and travel the other way, one segment per cycle. A writeback updates its bank when it reaches the owning segment, and a bank write lands before a read in the same cycle. Every resolved, register-sourced operand that meets the writeback on the way takes the new data. This includes operands that cross it between two adjacent segments. The register number kept in the token is what makes this late matching possible. If a token reaches the ALU end still marked as a number, the block raises a machine-check error. With legal inputs this cannot happen.

Top module: `regchain`

## Requirements
- R1: While reset is held and on the first cycle after it, no operand output is valid and the error output is low. After reset every register reads as zero.
- R2: An operand presented at decode with its valid bit set appears at the ALU side exactly NSEG cycles later, in the same slot (0 or 1), with its valid bit set.
- R3: An operand whose decode flag `dec_imm` is 1 arrives carrying exactly its `dec_val` slice. Writebacks never change it, including writebacks to the register number driven on `dec_rn` for that slot.
- R4: Register r (r = 0..NSEG*RPS-1) is owned by segment r / RPS, that is, by the upper bits of the number. A register operand returns the last value written to r.
- R5: A writeback to r changes what every later read of r returns, and leaves every other register unchanged.
- R6: An operand injected at cycle c sees every writeback presented at the port in cycles up to and including c+NSEG-1. It sees none presented at c+NSEG or later.
- R7: When several writebacks to one register are in flight at once, an operand receives the value of the youngest one that R6 admits.
- R8: The two operand slots are independent. They may name the same register, or one may be an immediate and the other a register.
- R9: A slot whose decode valid bit is 0 stays invalid at the ALU side and causes neither a read nor an error.
- R10: `alu_err` is high only when a valid token reaches the ALU end still marked as a register number. Under legal inputs it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld | input | 2 | Operand valid per slot (bit k is slot k) |
| dec_imm | input | 2 | 1: slot carries an immediate; 0: slot names a register |
| dec_rn | input | 2*RW | Register number per slot, slot k at bits [k*RW +: RW] |
| dec_val | input | 2*DW | Immediate value per slot, slot k at bits [k*DW +: DW] |
| wb_vld | input | 1 | Writeback valid at the ALU end |
| wb_rn | input | RW | Writeback register number |
| wb_val | input | DW | Writeback data |
| alu_vld | output | 2 | Resolved operand valid per slot |
| alu_val | output | 2*DW | Resolved operand value per slot, slot k at bits [k*DW +: DW] |
| alu_err | output | 1 | Machine check: an unresolved token reached the ALU end |

## Verification
The hardest case to reach is a writeback and an operand for the same register that pass each other between two adjacent segments within a single cycle, because they never sit in the same segment. The related edge is the last cycle in which a writeback still reaches an operand. To reach both, the stimulus injects a read of one register and presents a writeback to that register at every offset from two cycles before to two cycles past the chain depth. It repeats this for registers owned by the first, a middle and the last segment. It then runs a long random mix confined to three registers with dense writebacks. A flat reference register file is updated at the port, and each expected value is taken from it when the result is due.

// File: rtl/regchain.sv
module regchain #(
  parameter int NSEG = 4,
  parameter int RPS  = 8,
  parameter int DW   = 32,
  localparam int NREG = NSEG * RPS,
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      dec_vld,
  input  logic [1:0]      dec_imm,
  input  logic [2*RW-1:0] dec_rn,
  input  logic [2*DW-1:0] dec_val,
  input  logic            wb_vld,
  input  logic [RW-1:0]   wb_rn,
  input  logic [DW-1:0]   wb_val,
  output logic [1:0]      alu_vld,
  output logic [2*DW-1:0] alu_val,
  output logic            alu_err
);
  localparam int LW = $clog2(RPS);
  localparam int SW = RW - LW;

  typedef struct packed {
    logic          v;
    logic          num;
    logic          rs;
    logic [RW-1:0] rn;
    logic [DW-1:0] d;
  } tok_t;

  typedef struct packed {
    logic          v;
    logic [RW-1:0] rn;
    logic [DW-1:0] d;
  } wb_t;

  function automatic tok_t resolve(tok_t t, wb_t a, wb_t b, logic [DW-1:0] rd, logic [SW-1:0] sid);
    tok_t r;
    r = t;
    if (t.v && t.num && t.rn[RW-1:LW] == sid) begin
      r.num = 1'b0;
      r.d   = (a.v && a.rn == t.rn) ? a.d : rd;
    end
    if (r.v && r.rs && !r.num && a.v && a.rn == r.rn) r.d = a.d;
    if (r.v && r.rs && !r.num && b.v && b.rn == r.rn) r.d = b.d;
    return r;
  endfunction

  logic [DW-1:0] rf  [NREG];
  tok_t          opq [NSEG][2];
  tok_t          nx  [NSEG][2];
  wb_t           wbq [NSEG+1];
  tok_t          dtok [2];

  assign wbq[NSEG] = '{v: wb_vld, rn: wb_rn, d: wb_val};

  for (genvar k = 0; k < 2; k++) begin : g_dec
    assign dtok[k] = '{v:   dec_vld[k],
                       num: !dec_imm[k],
                       rs:  !dec_imm[k],
                       rn:  dec_imm[k] ? '0 : dec_rn[k*RW +: RW],
                       d:   dec_imm[k] ? dec_val[k*DW +: DW] : '0};
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    wb_t  w2;
    tok_t ti [2];
    if (s + 2 <= NSEG) begin : g_w2
      assign w2 = wbq[s+2];
    end else begin : g_nw2
      assign w2 = '0;
    end
    for (genvar k = 0; k < 2; k++) begin : g_op
      if (s == 0) begin : g_first
        assign ti[k] = dtok[k];
      end else begin : g_rest
        assign ti[k] = opq[s-1][k];
      end
      assign nx[s][k] = resolve(ti[k], wbq[s+1], w2, rf[ti[k].rn], SW'(s));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      for (int s = 0; s < NSEG; s++) begin
        wbq[s] <= '0;
        for (int k = 0; k < 2; k++) opq[s][k] <= '0;
      end
    end else begin
      for (int s = 0; s < NSEG; s++) begin
        if (wbq[s+1].v && wbq[s+1].rn[RW-1:LW] == SW'(s)) rf[wbq[s+1].rn] <= wbq[s+1].d;
        wbq[s] <= wbq[s+1];
        for (int k = 0; k < 2; k++) opq[s][k] <= nx[s][k];
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_out
    assign alu_vld[k]          = opq[NSEG-1][k].v;
    assign alu_val[k*DW +: DW] = opq[NSEG-1][k].d;
  end

  assign alu_err = (opq[NSEG-1][0].v && opq[NSEG-1][0].num) ||
                   (opq[NSEG-1][1].v && opq[NSEG-1][1].num);
endmodule

// File: rtl/regchain_chk.sv
module regchain_chk #(
  parameter int NSEG = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      dec_vld,
  input logic [1:0]      dec_imm,
  input logic [2*DW-1:0] dec_val,
  input logic [1:0]      alu_vld,
  input logic [2*DW-1:0] alu_val,
  input logic            alu_err
);
  logic [1:0]      pv [NSEG];
  logic [1:0]      pi [NSEG];
  logic [2*DW-1:0] pd [NSEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSEG; s++) begin
        pv[s] <= '0;
        pi[s] <= '0;
        pd[s] <= '0;
      end
    end else begin
      pv[0] <= dec_vld;
      pi[0] <= dec_imm;
      pd[0] <= dec_val;
      for (int s = 1; s < NSEG; s++) begin
        pv[s] <= pv[s-1];
        pi[s] <= pi[s-1];
        pd[s] <= pd[s-1];
      end
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (alu_vld == 2'b00 && !alu_err));

  // R2
  lat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n) alu_vld == pv[NSEG-1]);

  // R10
  no_mchk_chk: assert property (@(posedge clk) disable iff (!rst_n) !alu_err);

  for (genvar k = 0; k < 2; k++) begin : g_imm
    // R3
    imm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv[NSEG-1][k] && pi[NSEG-1][k]) |-> alu_val[k*DW +: DW] == pd[NSEG-1][k*DW +: DW]);
  end
endmodule

bind regchain regchain_chk #(.NSEG(NSEG), .DW(DW)) u_regchain_chk (
  .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_imm(dec_imm), .dec_val(dec_val),
  .alu_vld(alu_vld), .alu_val(alu_val), .alu_err(alu_err));

// File: tb/test_regchain.sv
`timescale 1ns/1ps
module test_regchain;
  localparam int NSEG = 4;
  localparam int RPS  = 8;
  localparam int DW   = 32;
  localparam int NREG = NSEG * RPS;
  localparam int RW   = $clog2(NREG);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      dec_vld = '0;
  logic [1:0]      dec_imm = '0;
  logic [2*RW-1:0] dec_rn = '0;
  logic [2*DW-1:0] dec_val = '0;
  logic            wb_vld = 1'b0;
  logic [RW-1:0]   wb_rn = '0;
  logic [DW-1:0]   wb_val = '0;
  logic [1:0]      alu_vld;
  logic [2*DW-1:0] alu_val;
  logic            alu_err;

  always #4 clk = ~clk;

  regchain #(.NSEG(NSEG), .RPS(RPS), .DW(DW)) i_regchain (.*);

  typedef struct {
    int            due;
    int            k;
    bit            imm;
    int            rn;
    logic [DW-1:0] v;
    string         req;
  } item_t;

  item_t         sq [$];
  logic [DW-1:0] refr [NREG];
  int            cyc = 0;
  int            total = 0;
  int            bad = 0;
  bit            done = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input bit [1:0] v, input bit [1:0] im, input int r0, input int r1,
                      input logic [DW-1:0] i0, input logic [DW-1:0] i1,
                      input bit wv, input int wr, input logic [DW-1:0] wd, input string req);
    logic [1:0] e;
    logic [DW-1:0] exp;
    @(negedge clk);
    cyc++;
    e = '0;
    while (sq.size() > 0 && sq[0].due == cyc) begin
      item_t it;
      it = sq.pop_front();
      e[it.k] = 1'b1;
      exp = it.imm ? it.v : refr[it.rn];
      chk(alu_val[it.k*DW +: DW] == exp, it.req, alu_val[it.k*DW +: DW], exp);
    end
    chk(alu_vld == e, "R2,R9", DW'(alu_vld), DW'(e));
    chk(!alu_err, "R10", DW'(alu_err), '0);
    dec_vld = v;
    dec_imm = im;
    dec_rn  = {RW'(r1), RW'(r0)};
    dec_val = {i1, i0};
    wb_vld  = wv;
    wb_rn   = RW'(wr);
    wb_val  = wd;
    for (int k = 0; k < 2; k++)
      if (v[k]) sq.push_back('{due: cyc + NSEG, k: k, imm: im[k], rn: (k == 0) ? r0 : r1,
                               v: (k == 0) ? i0 : i1, req: req});
    if (wv) refr[wr] = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, 2'b00, 0, 0, '0, '0, 1'b0, 0, '0, "R9");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) refr[i] = '0;
    repeat (3) @(negedge clk);
    chk(alu_vld == 2'b00 && !alu_err, "R1", DW'({alu_err, alu_vld}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(alu_vld == 2'b00 && !alu_err, "R1", DW'({alu_err, alu_vld}), '0);

    // R1: every register reads zero after reset
    for (int r = 0; r < NREG; r += 2) step(2'b11, 2'b00, r, r + 1, '0, '0, 1'b0, 0, '0, "R1");
    idle(NSEG + 1);

    // R4 / R5: fill all registers, then read them back
    for (int r = 0; r < NREG; r++) step(2'b00, 2'b00, 0, 0, '0, '0, 1'b1, r, 32'hA500_0000 + r * 32'h111, "R5");
    idle(NSEG + 2);
    for (int r = 0; r < NREG; r += 2) step(2'b11, 2'b00, r + 1, r, '0, '0, 1'b0, 0, '0, "R4");
    idle(NSEG + 1);

    // R3: immediates while writebacks hit the same register numbers
    for (int i = 0; i < 12; i++)
      step(2'b11, 2'b11, 7, 7, 32'hC0DE_0000 + i, 32'hFACE_0000 + i, 1'b1, 7, $urandom, "R3");
    idle(NSEG + 1);

    // R6: writeback offset sweep across the forwarding window edge
    foreach (int_regs_dummy[j]) ;
    for (int j = 0; j < 3; j++) begin
      int rr;
      rr = (j == 0) ? 0 : (j == 1) ? 13 : NREG - 1;
      for (int d = -2; d <= NSEG + 2; d++) begin
        for (int t = -2; t <= NSEG + 2; t++) begin
          bit rd;
          bit wv;
          rd = (t == 0);
          wv = (t == d);
          step(rd ? 2'b01 : 2'b00, 2'b00, rr, 0, '0, '0, wv, rr, {16'hBEEF, 8'(d + 8), 8'(rr)}, "R6");
        end
        idle(NSEG + 1);
      end
    end

    // R7: back-to-back writebacks to one register with reads in flight
    for (int i = 0; i < 10; i++)
      step(2'b01, 2'b00, 21, 0, '0, '0, 1'b1, 21, 32'h7700_0000 + i, "R7");
    idle(NSEG + 1);

    // R8: same register on both slots, and mixed immediate/register
    step(2'b11, 2'b00, 9, 9, '0, '0, 1'b0, 0, '0, "R8");
    step(2'b11, 2'b01, 0, 9, 32'h1234_5678, '0, 1'b1, 9, 32'h0BAD_F00D, "R8");
    step(2'b11, 2'b10, 9, 0, '0, 32'h8765_4321, 1'b0, 0, '0, "R8");
    idle(NSEG + 1);

    // R9: sparse slots
    for (int i = 0; i < 8; i++) step(2'(i % 3), 2'b00, 3, 30, '0, '0, 1'b0, 0, '0, "R9");
    idle(NSEG + 1);

    // R6 / R7: random contention on three registers
    for (int i = 0; i < 3000; i++) begin
      int pick [3];
      pick = '{5, 18, 29};
      step(2'($urandom), 2'($urandom % 4 == 0 ? 2'b01 : 2'b00), pick[$urandom % 3], pick[$urandom % 3],
           $urandom, $urandom, 1'($urandom % 3 != 0), pick[$urandom % 3], $urandom, "R6");
    end
    idle(NSEG + 2);
    finish_run();
  end

  int int_regs_dummy [1];
endmodule